// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control engine of one DMA channel. Software fills a chain of 32-byte descriptors in memory. It points the channel at the first descriptor, enables the channel and rings the doorbell. The sequencer then works through the chain on its own. For each descriptor it reads all eight words over a simple request/acknowledge memory port and checks the valid flag. It hands the byte count to the datapath over a request/done handshake. When the transfer ends it runs the completion actions the descriptor selects, then follows the next-descriptor link. The walk continues until a descriptor with its valid flag clear is found, and there the channel halts.

A small register file carries the channel state for software: the enable, the descriptor and status pointers, the doorbell, a write-one-to-clear interrupt pending flag, three status flags and the remaining byte count. The datapath itself, arbitration against other channels and cache coherency sit outside this block.

Top module: `dchain_seq`

## Requirements
- R1: After reset all registers read zero (register indices: 0 enable in bit 0, 1 descriptor pointer, 2 status pointer, 3 doorbell, 4 interrupt pending in bit 0, 5 status, 6 remaining byte count). `irq_o`, `mem_req_o` and `xfer_req_o` are low.
- R2: Any write to register 3 sets status bit 2 (doorbell pending). Fetching starts only while register 0 bit 0 is set. A fetch reads the eight descriptor words in order from the descriptor address, and the doorbell bit clears when a fetch begins.
- R3: A descriptor whose word 0 bit 31 is clear halts the channel. Status bit 0 is set, no transfer or write takes place, and the descriptor pointer keeps that address, so the next doorbell fetches the same descriptor again.
- R4: For a valid descriptor, `xfer_bytes_o` carries word 1 bits 21:0. `xfer_req_o` stays high until `xfer_done_i`, and register 6 then reads the `xfer_rem_i` value given with done.
- R5: Word 0 bits 1:0 choose the status write after the transfer: 0 writes nothing; 1 writes the status register value (bit 2 doorbell, bit 1 descriptor valid, bit 0 halted); 2 writes word 0 with bit 31 cleared; 3 writes the remaining byte count.
- R6: The status word goes to the status pointer register (low two bits zero) when word 0 bit 4 is set, and otherwise to the descriptor's word 6 (base + 24).
- R7: When word 0 bit 2 is set, word 0 is written back to the descriptor base with bit 31 cleared, after any status write. No word the channel writes has bit 31 set.
- R8: Every completed descriptor sets register 4 bit 0, whatever word 0 bit 8 holds. `irq_o` is high only while that bit is pending and a descriptor with bit 8 set has completed since the last clear. Writing 1 to register 4 bit 0 clears it; writing 0 has no effect.
- R9: On completion the descriptor pointer becomes word 7 bits 26:0 shifted left by 5. The channel fetches from there without a new doorbell.
- R10: If the enable is cleared during a descriptor, that descriptor still completes. The channel then stops at the boundary with the pointer advanced and issues no further memory requests.
- R11: A doorbell written while a descriptor is in progress leaves status bit 2 set until the next fetch begins. If the channel stopped on a cleared enable, setting the enable again starts that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata_i | input | 32 | Memory read data |
| xfer_req_o | output | 1 | Transfer request to the datapath |
| xfer_bytes_o | output | 22 | Byte count of the transfer |
| xfer_done_i | input | 1 | Transfer finished |
| xfer_rem_i | input | 22 | Bytes left over, valid with done |
| irq_o | output | 1 | Channel interrupt |

## Verification
A register write takes effect at the clock edge where it is sampled. A doorbell written to an idle, enabled channel raises the first read request one cycle later. Each memory access then finishes on the edge where the acknowledge is seen, and with the bench's memory an access lasts two cycles. The scoreboard does not count cycles for writes and transfers. It pops an expected address/data pair or byte count at the moment the bench's memory or datapath model sees the request, so those checks are tied to the handshake and not to a fixed latency. Register results (pointer, status, count, interrupt) are read only after the channel is known to be at rest: polled until the halted flag is set, or after a fixed wait longer than one descriptor. Every read samples on the falling edge.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int DW = 32;

  localparam logic [2:0] REG_CFG  = 3'd0;
  localparam logic [2:0] REG_DPTR = 3'd1;
  localparam logic [2:0] REG_SPTR = 3'd2;
  localparam logic [2:0] REG_DBEL = 3'd3;
  localparam logic [2:0] REG_IRQ  = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;
  localparam logic [2:0] REG_BCNT = 3'd6;

  // descriptor word 0 bit positions
  localparam int C0_VALID = 31;
  localparam int C0_IE    = 8;
  localparam int C0_SPSEL = 4;
  localparam int C0_CLRV  = 2;

  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_CUR  = 2'd1,
    ST_CMD  = 2'd2,
    ST_REM  = 2'd3
  } stat_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_XFER, S_STAT, S_CLRV, S_NEXT
  } seq_state_e;
endpackage

// File: rtl/dchain_regs.sv
module dchain_regs
  import dchain_pkg::*;
#(
  parameter int BCW = 22,
  parameter int ALB = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [2:0]     addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           en_o,
  output logic [DW-1:0]  dptr_o,
  output logic [DW-1:0]  sptr_o,
  output logic [2:0]     status_o,
  output logic           pend_o,
  output logic           irq_o,
  input  logic           fetch_start_i,
  input  logic           halt_i,
  input  logic           valid_set_i,
  input  logic           done_i,
  input  logic           done_ie_i,
  input  logic [DW-1:0]  nxt_ptr_i,
  input  logic           bc_load_i,
  input  logic [BCW-1:0] bc_val_i
);
  localparam logic [DW-1:0] DPTR_MASK = ~DW'((1 << ALB) - 1);
  localparam logic [DW-1:0] SPTR_MASK = ~DW'(3);

  logic           en_q, db_q, v_q, h_q, pend_q, ie_q;
  logic [DW-1:0]  dptr_q, sptr_q;
  logic [BCW-1:0] bc_q;

  logic wr_cfg, wr_dptr, wr_sptr, wr_db, irq_clr;
  assign wr_cfg  = wr_i && addr_i == REG_CFG;
  assign wr_dptr = wr_i && addr_i == REG_DPTR;
  assign wr_sptr = wr_i && addr_i == REG_SPTR;
  assign wr_db   = wr_i && addr_i == REG_DBEL;
  assign irq_clr = wr_i && addr_i == REG_IRQ && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      db_q   <= 1'b0;
      v_q    <= 1'b0;
      h_q    <= 1'b0;
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
      dptr_q <= '0;
      sptr_q <= '0;
      bc_q   <= '0;
    end else begin
      if (wr_cfg) en_q <= wdata_i[0];
      if (wr_sptr) sptr_q <= wdata_i & SPTR_MASK;
      if (done_i) dptr_q <= nxt_ptr_i;
      else if (wr_dptr) dptr_q <= wdata_i & DPTR_MASK;
      if (wr_db) db_q <= 1'b1;
      else if (fetch_start_i) db_q <= 1'b0;
      if (halt_i) h_q <= 1'b1;
      else if (fetch_start_i) h_q <= 1'b0;
      if (valid_set_i) v_q <= 1'b1;
      else if (done_i) v_q <= 1'b0;
      if (done_i) begin
        pend_q <= 1'b1;
        if (done_ie_i) ie_q <= 1'b1;
      end else if (irq_clr) begin
        pend_q <= 1'b0;
        ie_q   <= 1'b0;
      end
      if (bc_load_i) bc_q <= bc_val_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CFG:  rdata_o[0] = en_q;
      REG_DPTR: rdata_o = dptr_q;
      REG_SPTR: rdata_o = sptr_q;
      REG_IRQ:  rdata_o[0] = pend_q;
      REG_STAT: rdata_o[2:0] = {db_q, v_q, h_q};
      REG_BCNT: rdata_o[BCW-1:0] = bc_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o     = en_q;
  assign dptr_o   = dptr_q;
  assign sptr_o   = sptr_q;
  assign status_o = {db_q, v_q, h_q};
  assign pend_o   = pend_q;
  assign irq_o    = pend_q & ie_q;
endmodule

// File: rtl/dchain_fsm.sv
module dchain_fsm
  import dchain_pkg::*;
#(
  parameter int BCW = 22,
  parameter int ALB = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           db_i,
  input  logic [DW-1:0]  dptr_i,
  input  logic [DW-1:0]  sptr_i,
  input  logic [2:0]     status_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_ack_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           xfer_req_o,
  output logic [BCW-1:0] xfer_bytes_o,
  input  logic           xfer_done_i,
  input  logic [BCW-1:0] xfer_rem_i,
  output logic           fetch_start_o,
  output logic           halt_o,
  output logic           valid_set_o,
  output logic           done_o,
  output logic           done_ie_o,
  output logic [DW-1:0]  nxt_ptr_o,
  output logic           bc_load_o,
  output logic [BCW-1:0] bc_val_o,
  output seq_state_e     state_o
);
  localparam int IDXW     = ALB - 2;
  localparam int NWORDS   = 1 << IDXW;
  localparam int STAT_IDX = NWORDS - 2;
  localparam int NXT_IDX  = NWORDS - 1;
  localparam int NXW      = DW - ALB;

  seq_state_e      state_q;
  logic [IDXW-1:0] idx_q;
  logic [DW-1:0]   base_q, cmd0_q;
  logic [BCW-1:0]  bc_q, rem_q;
  logic [NXW-1:0]  nxt_q;

  stat_op_e st_op;
  logic     last_word, cmd_valid, start_idle, start_next;
  logic [DW-1:0] cmd0_inv, stat_word;

  assign st_op      = stat_op_e'(cmd0_q[1:0]);
  assign last_word  = idx_q == IDXW'(NXT_IDX);
  assign cmd_valid  = cmd0_q[C0_VALID];
  assign cmd0_inv   = cmd0_q & ~(DW'(1) << C0_VALID);
  assign nxt_ptr_o  = {nxt_q, {ALB{1'b0}}};
  assign start_idle = state_q == S_IDLE && en_i && db_i;
  assign start_next = state_q == S_NEXT && en_i;

  always_comb begin
    unique case (st_op)
      ST_CUR:  stat_word = {{(DW-3){1'b0}}, status_i};
      ST_CMD:  stat_word = cmd0_inv;
      ST_REM:  stat_word = {{(DW-BCW){1'b0}}, rem_q};
      default: stat_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      cmd0_q  <= '0;
      bc_q    <= '0;
      rem_q   <= '0;
      nxt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_idle) begin
          base_q  <= dptr_i;
          idx_q   <= '0;
          state_q <= S_FETCH;
        end
        S_FETCH: if (mem_ack_i) begin
          if (idx_q == IDXW'(0)) cmd0_q <= mem_rdata_i;
          if (idx_q == IDXW'(1)) bc_q <= mem_rdata_i[BCW-1:0];
          if (last_word) begin
            nxt_q   <= mem_rdata_i[NXW-1:0];
            state_q <= S_CHECK;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_CHECK: state_q <= cmd_valid ? S_XFER : S_IDLE;
        S_XFER: if (xfer_done_i) begin
          rem_q <= xfer_rem_i;
          if (st_op != ST_NONE)    state_q <= S_STAT;
          else if (cmd0_q[C0_CLRV]) state_q <= S_CLRV;
          else                      state_q <= S_NEXT;
        end
        S_STAT: if (mem_ack_i) state_q <= cmd0_q[C0_CLRV] ? S_CLRV : S_NEXT;
        S_CLRV: if (mem_ack_i) state_q <= S_NEXT;
        S_NEXT: begin
          if (en_i) begin
            base_q  <= nxt_ptr_o;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    unique case (state_q)
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base_q + {{(DW-ALB){1'b0}}, idx_q, 2'b00};
      end
      S_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cmd0_q[C0_SPSEL] ? sptr_i : base_q + DW'(STAT_IDX * 4);
        mem_wdata_o = stat_word;
      end
      S_CLRV: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = cmd0_inv;
      end
      default: ;
    endcase
  end

  assign xfer_req_o    = state_q == S_XFER;
  assign xfer_bytes_o  = bc_q;
  assign fetch_start_o = start_idle || start_next;
  assign halt_o        = state_q == S_CHECK && !cmd_valid;
  assign valid_set_o   = state_q == S_CHECK && cmd_valid;
  assign done_o        = state_q == S_NEXT;
  assign done_ie_o     = cmd0_q[C0_IE];
  assign bc_load_o     = valid_set_o || (state_q == S_XFER && xfer_done_i);
  assign bc_val_o      = state_q == S_XFER ? xfer_rem_i : bc_q;
  assign state_o       = state_q;
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
  import dchain_pkg::*;
#(
  parameter int BCW = 22,
  parameter int ALB = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_wr_i,
  input  logic [2:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [31:0]    mem_addr_o,
  output logic [31:0]    mem_wdata_o,
  input  logic           mem_ack_i,
  input  logic [31:0]    mem_rdata_i,
  output logic           xfer_req_o,
  output logic [BCW-1:0] xfer_bytes_o,
  input  logic           xfer_done_i,
  input  logic [BCW-1:0] xfer_rem_i,
  output logic           irq_o
);
  logic           en, pend, fetch_start, halt, valid_set, done, done_ie, bc_load;
  logic [DW-1:0]  dptr, sptr, nxt_ptr;
  logic [2:0]     status;
  logic [BCW-1:0] bc_val;
  seq_state_e     seq_state;

  dchain_regs #(.BCW(BCW), .ALB(ALB)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .en_o(en), .dptr_o(dptr), .sptr_o(sptr), .status_o(status), .pend_o(pend), .irq_o,
    .fetch_start_i(fetch_start), .halt_i(halt), .valid_set_i(valid_set),
    .done_i(done), .done_ie_i(done_ie), .nxt_ptr_i(nxt_ptr),
    .bc_load_i(bc_load), .bc_val_i(bc_val)
  );

  dchain_fsm #(.BCW(BCW), .ALB(ALB)) u_fsm (
    .clk_i, .rst_ni,
    .en_i(en), .db_i(status[2]), .dptr_i(dptr), .sptr_i(sptr), .status_i(status),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .xfer_req_o, .xfer_bytes_o, .xfer_done_i, .xfer_rem_i,
    .fetch_start_o(fetch_start), .halt_o(halt), .valid_set_o(valid_set),
    .done_o(done), .done_ie_o(done_ie), .nxt_ptr_o(nxt_ptr),
    .bc_load_o(bc_load), .bc_val_o(bc_val), .state_o(seq_state)
  );
endmodule

// File: rtl/dchain_seq_chk.sv
module dchain_seq_chk
  import dchain_pkg::*;
#(
  parameter int BCW = 22
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [31:0]    mem_addr_o,
  input logic [31:0]    mem_wdata_o,
  input logic           mem_ack_i,
  input logic           xfer_req_o,
  input logic [BCW-1:0] xfer_bytes_o,
  input logic           xfer_done_i,
  input logic [2:0]     status,
  input logic           en,
  input logic           done,
  input logic           pend,
  input seq_state_e     seq_state
);
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r4_xfer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i |=> xfer_req_o && $stable(xfer_bytes_o));

  a_r3_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[0] |-> !mem_req_o && !xfer_req_o);

  a_r7_written_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

  a_r8_done_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> pend);

  a_r10_off_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_state == S_IDLE && !en |=> !mem_req_o);

  a_r4_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && xfer_req_o));
endmodule

bind dchain_seq dchain_seq_chk #(.BCW(BCW)) u_chk (
  .clk_i, .rst_ni, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i,
  .xfer_req_o, .xfer_bytes_o, .xfer_done_i,
  .status(status), .en(en), .done(done), .pend(pend), .seq_state(seq_state)
);

// File: tb/dchain_seq_bench.sv
module dchain_seq_bench;
  localparam int BCW = 22;
  localparam logic [31:0] V  = 32'h8000_0000;
  localparam logic [31:0] IE = 32'h100;
  localparam logic [31:0] SP = 32'h10;
  localparam logic [31:0] CV = 32'h4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic xfer_req, xfer_done = 1'b0;
  logic [BCW-1:0] xfer_bytes, xfer_rem = '0;
  logic irq;

  int n_cmp = 0, n_bad = 0, rd_cnt = 0, dp_lat = 3, dp_cnt = 0;
  logic [BCW-1:0] dp_rem = '0;
  logic [31:0] mem [64];

  logic [63:0] exp_wr [$];
  string       exp_tag [$];
  logic [BCW-1:0] exp_bc [$];

  always #5 clk = ~clk;

  dchain_seq u_dchain_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xfer_req_o(xfer_req), .xfer_bytes_o(xfer_bytes), .xfer_done_i(xfer_done),
    .xfer_rem_i(xfer_rem), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push_wr(input string req, input logic [31:0] a, input logic [31:0] d);
    exp_wr.push_back({a, d});
    exp_tag.push_back(req);
  endtask

  // memory model and write scoreboard monitor
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (rst_n && mem_req) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[7:2]] = mem_wdata;
        if (exp_wr.size() == 0) check("R5 unexpected write", mem_addr, 32'hFFFF_FFFF);
        else begin
          logic [63:0] e;
          string t;
          e = exp_wr.pop_front();
          t = exp_tag.pop_front();
          check({t, " wr addr"}, mem_addr, e[63:32]);
          check({t, " wr data"}, mem_wdata, e[31:0]);
        end
      end else begin
        mem_rdata <= mem[mem_addr[7:2]];
        rd_cnt++;
      end
    end
  end

  // datapath stub and transfer monitor
  always @(negedge clk) begin
    if (xfer_done) xfer_done <= 1'b0;
    else if (rst_n && xfer_req) begin
      dp_cnt++;
      if (dp_cnt >= dp_lat) begin
        dp_cnt = 0;
        xfer_done <= 1'b1;
        xfer_rem <= dp_rem;
        if (exp_bc.size() == 0) check("R4 unexpected xfer", 32'(xfer_bytes), 32'hFFFF_FFFF);
        else check("R4 xfer bytes", 32'(xfer_bytes), 32'(exp_bc.pop_front()));
      end
    end
  end

  task automatic reg_w(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_r(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_halt();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      reg_r(3'd5, s);
      if (s[0]) break;
    end
  endtask

  task automatic queues_empty(input string req);
    check({req, " pending writes"}, 32'(exp_wr.size()), 32'd0);
    check({req, " pending xfers"}, 32'(exp_bc.size()), 32'd0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int rd0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      reg_r(3'(a), r);
      check("R1 reg reset", r, 32'd0);
    end
    check("R1 irq", 32'(irq), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 xfer_req", 32'(xfer_req), 0);

    // T1: three-descriptor chain
    mem[0]  = V | IE | 32'd1;  mem[1]  = 32'd16;  mem[7]  = 32'd1;
    mem[8]  = V | SP | CV | 32'd2; mem[9] = 32'd100; mem[15] = 32'd2;
    mem[16] = 32'd0;
    reg_w(3'd2, 32'hE0);
    reg_w(3'd1, 32'h0);
    reg_w(3'd3, 32'h1234);
    repeat (20) @(negedge clk);
    check("R2 no fetch while disabled", 32'(rd_cnt), 0);
    reg_r(3'd5, r);
    check("R2 doorbell bit", r, 32'h4);
    push_wr("R5", 32'h18, 32'h2);
    push_wr("R6", 32'hE0, 32'h0000_0016);
    push_wr("R7", 32'h20, 32'h0000_0016);
    exp_bc.push_back(22'd16);
    exp_bc.push_back(22'd100);
    reg_w(3'd0, 32'h1);
    wait_halt();
    check("R2 eight reads per descriptor", 32'(rd_cnt), 24);
    reg_r(3'd1, r); check("R9 pointer follows chain", r, 32'h40);
    reg_r(3'd5, r); check("R3 halted status", r, 32'h1);
    reg_r(3'd4, r); check("R8 pending", r, 32'h1);
    check("R8 irq with enable", 32'(irq), 1);
    reg_r(3'd6, r); check("R4 remaining", r, 32'h0);
    check("R7 valid cleared in memory", mem[8], 32'h16);
    queues_empty("R5");
    reg_w(3'd4, 32'h0);
    reg_r(3'd4, r); check("R8 write zero keeps pending", r, 32'h1);
    reg_w(3'd4, 32'h1);
    reg_r(3'd4, r); check("R8 w1c", r, 32'h0);
    check("R8 irq cleared", 32'(irq), 0);

    // T2: restart from halted slot, masked interrupt, remaining count
    mem[16] = V | 32'd3; mem[17] = 32'd40; mem[23] = 32'd3;
    mem[24] = V;         mem[25] = 32'd8;  mem[31] = 32'd4;
    mem[32] = 32'd0;
    dp_rem = 22'd12;
    rd0 = rd_cnt;
    push_wr("R5", 32'h58, 32'd12);
    exp_bc.push_back(22'd40);
    exp_bc.push_back(22'd8);
    reg_w(3'd3, 32'h0);
    wait_halt();
    check("R3 refetch count", 32'(rd_cnt - rd0), 24);
    reg_r(3'd1, r); check("R9 pointer", r, 32'h80);
    reg_r(3'd6, r); check("R4 remaining", r, 32'd12);
    reg_r(3'd4, r); check("R8 pending without enable", r, 32'h1);
    check("R8 irq masked", 32'(irq), 0);
    check("R7 no clear without flag", mem[24], V);
    queues_empty("R5");

    // T3: enable dropped mid-descriptor, doorbell while busy
    reg_w(3'd4, 32'h1);
    mem[40] = V | 32'd1; mem[41] = 32'd4; mem[47] = 32'd6;
    mem[48] = V;         mem[49] = 32'd4; mem[55] = 32'd4;
    dp_rem = '0;
    dp_lat = 20;
    reg_w(3'd1, 32'hA0);
    push_wr("R11", 32'hB8, 32'h6);
    exp_bc.push_back(22'd4);
    exp_bc.push_back(22'd4);
    rd0 = rd_cnt;
    reg_w(3'd3, 32'h0);
    for (int i = 0; i < 500 && !xfer_req; i++) @(negedge clk);
    reg_w(3'd3, 32'h0);
    reg_r(3'd5, r); check("R11 doorbell latched while busy", r, 32'h6);
    reg_w(3'd0, 32'h0);
    repeat (80) @(negedge clk);
    reg_r(3'd1, r); check("R10 pointer advanced", r, 32'hC0);
    reg_r(3'd5, r); check("R10 stopped with doorbell pending", r, 32'h4);
    check("R10 no fetch after stop", 32'(rd_cnt - rd0), 8);
    rd0 = rd_cnt;
    reg_w(3'd0, 32'h1);
    wait_halt();
    check("R11 resumed fetch count", 32'(rd_cnt - rd0), 16);
    reg_r(3'd1, r); check("R11 pointer", r, 32'h80);
    reg_r(3'd5, r); check("R11 halted", r, 32'h1);
    queues_empty("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule